// File: doc/BRIEF.md
# Depth-Cascade Token Controller

This block joins several identical FIFO slices into one deeper queue. All slices see the same write strobe, the same write data, the same read strobe, and drive one shared read-data path. Each slice holds a write token and a read token. A slice acts on a shared strobe only while it holds the matching token. When a slice writes its last physical location, it sends the write token to the next slice in a ring through its expansion output. It does the same with the read token when it reads its last physical location. The words therefore leave the ring in the order they entered, with no word stored twice.

Each slice picks its operating mode during reset from two inputs: its expansion input and its first-load input. A low write field on the expansion input selects standalone mode. A high write field with first-load low selects the master, which starts with both tokens. A high write field with first-load high selects a slave, which starts with none. A standalone slice keeps both tokens for good and uses the write field of its expansion output as an active-low half-full flag. The top level holds three slices, each with a small parameterized memory, joined in a ring. It combines the per-slice flags. It models the shared read-data wiring as a multiplexer driven by the slice whose read just completed. An input, `ring_en`, chooses at reset between the ring and a single standalone slice. It must be held steady outside reset.

Top module: `dcq_ring`

## Requirements
- R1: After reset with `ring_en` high, slice 0 is master and slices 1 and 2 are slaves. `empty_n` is 0, `full_n` is 1, `half_full_n` is 1, `rd_valid` is 0, and `wr_sel` and `rd_sel` are both 3'b001 (bit i is slice i).
- R2: In ring mode, accepted writes fill slice 0, then slice 1, then slice 2, then slice 0 again. Each slice takes DEPTH words per visit. After k accepted writes since reset, `wr_sel` has only bit (k / DEPTH) mod 3 set.
- R3: `wr_sel` and `rd_sel` each have exactly one bit set at all times after reset. Exactly one slice responds to any write, and exactly one to any read.
- R4: A read accepted at a clock edge shows `rd_valid` = 1 and the read word on `rd_data` after that edge, for one cycle. Words come out in the order they were written, across slice boundaries.
- R5: A slice gives up a token only on an accepted write (or read) of its last physical location. The next slice in the ring responds to the very next strobe, with no idle cycle. After k accepted reads, `rd_sel` has only bit (k / DEPTH) mod 3 set.
- R6: `full_n` is 0 exactly when the ring holds 3*DEPTH unread words. A write strobe while `full_n` is 0 stores nothing and moves no token.
- R7: `empty_n` is 0 exactly when no unread word is held. A read strobe while `empty_n` is 0 gives no `rd_valid` and moves no token.
- R8: A write and a read that both hit their slices' last locations at the same edge pass both tokens at once. The expansion link has separate write and read fields.
- R9: With `ring_en` low at reset, slice 0 runs standalone as a FIFO of DEPTH words that wraps in place. `wr_sel` and `rd_sel` stay 3'b001. `full_n` is 0 at DEPTH words. `half_full_n` is 0 while more than DEPTH/2 words are held. In ring mode `half_full_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; modes are sampled while low |
| ring_en | input | 1 | 1: three slices in a ring; 0: slice 0 standalone |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | DW | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | DW | Read word, valid with rd_valid |
| rd_valid | output | 1 | Read word present this cycle |
| full_n | output | 1 | Composite active-low full flag |
| empty_n | output | 1 | Composite active-low empty flag |
| half_full_n | output | 1 | Active-low half-full flag (standalone only) |
| wr_sel | output | NUM_SLICES | One-hot: slice that holds the write token |
| rd_sel | output | NUM_SLICES | One-hot: slice that holds the read token |

## Verification
The main function is tried with four patterns. A plain fill followed by a plain drain shows whether tokens move at the right word count and whether the order holds across every slice boundary and the ring wrap. Strobes against a full ring and against an empty ring show that refused requests store nothing and move nothing. A primed ring with a write and a read on every cycle makes both tokens leave their slices at the same edge, which separates a link with two fields from one that drops a token. An irregular mixed stream, and the same traffic with the ring disabled, compare the block against a queue model kept in the bench, including standalone wrap and the half-full threshold.

// File: rtl/dcq_pkg.sv
package dcq_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO   = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2
  } dcq_mode_e;

  // Expansion link: separate active-low fields for the two tokens (R8)
  typedef struct packed {
    logic wtok_n;
    logic rtok_n;
  } xlink_t;

  // Mode choice sampled during reset
  function automatic dcq_mode_e decode_mode(input logic xi_w_n, input logic first_n);
    if (!xi_w_n)       return MODE_SOLO;
    else if (!first_n) return MODE_MASTER;
    else               return MODE_SLAVE;
  endfunction

  // Half-full test: strictly more than half of the slice occupied
  function automatic logic over_half(input int unsigned used, input int unsigned depth);
    return used > (depth / 2);
  endfunction

endpackage

// File: rtl/dcq_mode_latch.sv
module dcq_mode_latch
  import dcq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xi_w_n,
  input  logic      first_n,
  output dcq_mode_e mode_now,
  output dcq_mode_e mode_q
);

  assign mode_now = decode_mode(xi_w_n, first_n);

  // Mode follows the pins only while reset is held (R1, R9)
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_now;
  end

endmodule

// File: rtl/dcq_token.sv
module dcq_token (
  input  logic clk,
  input  logic rst_n,
  input  logic init_hold,
  input  logic solo,
  input  logic pulse_in_n,
  input  logic fire_last,
  output logic holds,
  output logic pulse_out_n
);

  logic tok_q;
  logic pls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_q <= init_hold;
      pls_q <= 1'b1;
    end else begin
      pls_q <= !(fire_last && !solo);
      if (solo)               tok_q <= 1'b1;
      else if (fire_last)     tok_q <= 1'b0;
      else if (!pulse_in_n)   tok_q <= 1'b1;
    end
  end

  // An arriving pulse grants the token in that same cycle (R5: no gap)
  assign holds       = solo | tok_q | !pulse_in_n;
  assign pulse_out_n = pls_q;

endmodule

// File: rtl/dcq_store.sv
module dcq_store #(
  parameter int DW    = 9,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_fire,
  output logic [$clog2(DEPTH+1)-1:0] used,
  output logic          w_last,
  output logic          r_last,
  output logic [DW-1:0] q,
  output logic          q_vld
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      if (wr_fire) wptr <= bump(wptr);
      if (rd_fire) begin
        rptr <= bump(rptr);
        q    <= mem[rptr];
      end
      q_vld <= rd_fire;
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign used   = cnt;
  assign w_last = (wptr == AW'(DEPTH-1));
  assign r_last = (rptr == AW'(DEPTH-1));

endmodule

// File: rtl/dcq_slice.sv
module dcq_slice
  import dcq_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xlink_t        xi_n,
  input  logic          first_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output xlink_t        xo_n,
  output logic          full_n,
  output logic          empty_n,
  output logic          hf_n,
  output logic [DW-1:0] q,
  output logic          q_vld,
  output logic          wr_hold,
  output logic          rd_hold,
  output logic          wr_fire,
  output logic          rd_fire
);

  localparam int CW = $clog2(DEPTH+1);

  dcq_mode_e     mode_now, mode_q;
  logic          solo;
  logic          init_hold;
  logic [CW-1:0] used;
  logic          w_last, r_last;
  logic          is_full, is_empty;
  logic [1:0]    last_v, pin_n, pout_n, hold_v;

  dcq_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .xi_w_n   (xi_n.wtok_n),
    .first_n  (first_n),
    .mode_now (mode_now),
    .mode_q   (mode_q)
  );

  assign solo      = (mode_q == MODE_SOLO);
  assign init_hold = (mode_now == MODE_MASTER) || (mode_now == MODE_SOLO);

  assign is_full  = (used == CW'(DEPTH));
  assign is_empty = (used == '0);

  // Index 0: write token, index 1: read token
  assign wr_hold = hold_v[0];
  assign rd_hold = hold_v[1];
  assign wr_fire = wr_en && wr_hold && !is_full;   // R6
  assign rd_fire = rd_en && rd_hold && !is_empty;  // R7

  assign last_v = {rd_fire && r_last, wr_fire && w_last};
  assign pin_n  = {xi_n.rtok_n, xi_n.wtok_n};

  for (genvar k = 0; k < 2; k++) begin : g_tok
    dcq_token u_tok (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_hold   (init_hold),
      .solo        (solo),
      .pulse_in_n  (pin_n[k]),
      .fire_last   (last_v[k]),
      .holds       (hold_v[k]),
      .pulse_out_n (pout_n[k])
    );
  end

  dcq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_data (wr_data),
    .rd_fire (rd_fire),
    .used    (used),
    .w_last  (w_last),
    .r_last  (r_last),
    .q       (q),
    .q_vld   (q_vld)
  );

  // Only the token holder reports a flag condition
  assign full_n  = !(wr_hold && is_full);
  assign empty_n = !(rd_hold && is_empty);
  assign hf_n    = !(solo && over_half(32'(used), DEPTH));  // R9

  // Standalone: the write field carries half-full instead of a token
  assign xo_n.wtok_n = solo ? hf_n : pout_n[0];
  assign xo_n.rtok_n = solo ? 1'b1 : pout_n[1];

endmodule

// File: rtl/dcq_ring.sv
module dcq_ring
  import dcq_pkg::*;
#(
  parameter int DW         = 9,
  parameter int DEPTH      = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ring_en,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  input  logic                  rd_en,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_valid,
  output logic                  full_n,
  output logic                  empty_n,
  output logic                  half_full_n,
  output logic [NUM_SLICES-1:0] wr_sel,
  output logic [NUM_SLICES-1:0] rd_sel
);

  xlink_t                xo_v [NUM_SLICES];
  xlink_t                xi_v [NUM_SLICES];
  logic [DW-1:0]         q_v  [NUM_SLICES];
  logic [NUM_SLICES-1:0] q_vld_v, full_v, empty_v, hf_v;
  logic [NUM_SLICES-1:0] wr_fire, rd_fire;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    if (i == 0) begin : g_head
      // First slice: closes the ring, or sees a low write field for standalone
      assign xi_v[i] = ring_en ? xo_v[NUM_SLICES-1] : xlink_t'(2'b00);
    end else begin : g_tail
      assign xi_v[i] = ring_en ? xo_v[i-1] : xlink_t'(2'b11);
    end

    dcq_slice #(.DW(DW), .DEPTH(DEPTH)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .xi_n    (xi_v[i]),
      .first_n ((i == 0) ? 1'b0 : 1'b1),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .xo_n    (xo_v[i]),
      .full_n  (full_v[i]),
      .empty_n (empty_v[i]),
      .hf_n    (hf_v[i]),
      .q       (q_v[i]),
      .q_vld   (q_vld_v[i]),
      .wr_hold (wr_sel[i]),
      .rd_hold (rd_sel[i]),
      .wr_fire (wr_fire[i]),
      .rd_fire (rd_fire[i])
    );
  end

  // Composite flags: any asserted active-low flag asserts the result
  assign full_n      = &full_v;
  assign empty_n     = &empty_v;
  assign half_full_n = &hf_v;

  // Shared output wiring modelled as a select by the slice that read (R4)
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (q_vld_v[i]) rd_data = q_v[i];
    end
  end
  assign rd_valid = |q_vld_v;

endmodule

// File: rtl/dcq_ring_chk.sv
module dcq_ring_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         full_n,
  input logic         empty_n,
  input logic         rd_valid,
  input logic [N-1:0] wr_sel,
  input logic [N-1:0] rd_sel,
  input logic [N-1:0] wr_fire,
  input logic [N-1:0] rd_fire
);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r3_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $onehot(wr_sel));

  a_r3_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $onehot(rd_sel));

  a_r3_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_fire) <= 1 && $countones(rd_fire) <= 1);

  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (wr_fire == '0));

  a_r7_no_data_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !empty_n) |=> !rd_valid);

  a_r5_wr_token_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen) && wr_sel != $past(wr_sel)) |-> $past(|wr_fire));

  a_r5_rd_token_moves_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen) && rd_sel != $past(rd_sel)) |-> $past(|rd_fire));

  a_r4_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rd_valid) |-> $past(|rd_fire));

endmodule

bind dcq_ring dcq_ring_chk #(.N(NUM_SLICES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .full_n   (full_n),
  .empty_n  (empty_n),
  .rd_valid (rd_valid),
  .wr_sel   (wr_sel),
  .rd_sel   (rd_sel),
  .wr_fire  (wr_fire),
  .rd_fire  (rd_fire)
);

// File: tb/tb_dcq_ring.sv
`timescale 1ns/1ps
module tb_dcq_ring;

  localparam int DW    = 9;
  localparam int DEPTH = 4;
  localparam int NS    = 3;

  logic          clk = 1'b0;
  logic          rst_n, ring_en, wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid, full_n, empty_n, half_full_n;
  logic [NS-1:0] wr_sel, rd_sel;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model
  logic [DW-1:0] model_q [$];
  int cap, wpos, rpos;
  bit solo_mode;
  logic [DW-1:0] next_word;

  always #5 clk = ~clk;

  dcq_ring #(.DW(DW), .DEPTH(DEPTH), .NUM_SLICES(NS)) dut (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n),
    .empty_n(empty_n), .half_full_n(half_full_n), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sel_of(input int pos);
    if (solo_mode) return 1;
    return 1 << ((pos / DEPTH) % NS);
  endfunction

  task automatic do_reset(input logic ring);
    @(negedge clk);
    rst_n = 1'b0; ring_en = ring; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_q.delete();
    solo_mode = !ring;
    cap  = ring ? NS*DEPTH : DEPTH;
    wpos = 0; rpos = 0;
    @(negedge clk);
  endtask

  // One cycle of stimulus with full comparison against the model
  task automatic op(input logic w, input logic r, input string tag);
    bit acc_w, acc_r;
    logic [DW-1:0] exp_d;
    int cnt;
    cnt   = model_q.size();
    acc_w = w && (cnt < cap);
    acc_r = r && (cnt > 0);
    exp_d = '0;
    wr_en = w; rd_en = r; wr_data = next_word;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (acc_r) begin
      exp_d = model_q.pop_front();
      rpos = (rpos + 1) % cap;
    end
    if (acc_w) begin
      model_q.push_back(next_word);
      wpos = (wpos + 1) % cap;
    end
    next_word = next_word + 1'b1;
    chk(tag, "rd_valid", int'(rd_valid), int'(acc_r));
    if (acc_r) chk(tag, "rd_data", int'(rd_data), int'(exp_d));
    chk(tag, "full_n", int'(full_n), int'(model_q.size() != cap));
    chk(tag, "empty_n", int'(empty_n), int'(model_q.size() != 0));
    chk(tag, "wr_sel", int'(wr_sel), sel_of(wpos));
    chk(tag, "rd_sel", int'(rd_sel), sel_of(rpos));
    chk("R3", "onehot", int'($onehot(wr_sel) && $onehot(rd_sel)), 1);
    chk("R9", "half_full_n", int'(half_full_n),
        int'(!(solo_mode && model_q.size() > DEPTH/2)));
  endtask

  task automatic t_reset_state();
    chk("R1", "empty_n", int'(empty_n), 0);
    chk("R1", "full_n", int'(full_n), 1);
    chk("R1", "half_full_n", int'(half_full_n), 1);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "wr_sel", int'(wr_sel), 1);
    chk("R1", "rd_sel", int'(rd_sel), 1);
  endtask

  task automatic t_read_empty();
    op(1'b0, 1'b1, "R7");
    op(1'b0, 1'b1, "R7");
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < NS*DEPTH; i++) op(1'b1, 1'b0, "R2");
    chk("R6", "full_n at capacity", int'(full_n), 0);
    op(1'b1, 1'b0, "R6");
    op(1'b1, 1'b0, "R6");
    for (int i = 0; i < NS*DEPTH; i++) op(1'b0, 1'b1, "R4");
    chk("R5", "rd_sel after ring wrap", int'(rd_sel), 1);
    op(1'b0, 1'b1, "R7");
  endtask

  task automatic t_dual_pass();
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, "R5");
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b1, "R8");
    chk("R8", "wr_sel after joint pass", int'(wr_sel), 3'b100);
    chk("R8", "rd_sel after joint pass", int'(rd_sel), 3'b010);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 90; i++) begin
      op((i % 3) != 2 || (i % 7) == 0, (i % 5) == 1 || (i % 5) == 3 || i > 60, "R4");
    end
  endtask

  task automatic t_solo();
    for (int i = 0; i < DEPTH + 2; i++) op(1'b1, 1'b0, "R9");
    chk("R9", "full_n at slice depth", int'(full_n), 0);
    for (int i = 0; i < DEPTH - 1; i++) op(1'b0, 1'b1, "R9");
    for (int i = 0; i < 3*DEPTH; i++) op(i % 2 == 0 || i > 8, i % 3 != 0, "R9");
    for (int i = 0; i < DEPTH + 1; i++) op(1'b0, 1'b1, "R9");
  endtask

  initial begin
    next_word = 9'h040;
    rst_n = 1'b0; ring_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    do_reset(1'b1);
    t_reset_state();
    t_read_empty();
    t_fill_drain();
    do_reset(1'b1);
    t_dual_pass();
    t_stream();
    do_reset(1'b0);
    t_solo();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule